// File: doc/BRIEF.md
# Unanimous-Vote Input Glitch Filter

This block cleans up one asynchronous digital input before edge-sensitive counting logic sees it. The raw line first passes through a two-flop synchroniser. A free-running prescaler then produces a sampling strobe from a selectable tap, so samples are taken once every 2^k system clocks. The samples are shifted into a short history register. The filtered level changes only when every sample in the selected window agrees on the new level. The window length is 2, 3, 5 or 8 samples.

Short bursts of chatter near a threshold crossing are therefore removed. Short drop-outs in an otherwise steady level are removed in the same way. The cost is edge timing: the output edge is quantised to one sample period and arrives a fixed number of samples after the input settles. Downstream counters get the clean level and a one-clock rise or fall strobe at each accepted transition.

Top module: `glitch_vote_filter`

## Requirements
- R1: While reset is asserted (rstN low), and in the first cycle after it is released, filtOut, riseStb and fallStb are all 0.
- R2: lenSel selects the vote window: 0 gives 2 samples, 1 gives 3, 2 gives 5 and 3 gives 8. A new level held for at least that many consecutive samples is adopted by filtOut.
- R3: A pulse that yields fewer consecutive agreeing samples than the window leaves filtOut unchanged, and no strobe is produced.
- R4: A gap in a steady high level that is shorter than the window is removed: filtOut stays 1 and fallStb stays 0. A gap as long as the window is passed through.
- R5: tapSel=k yields one sample every 2^k clocks. A pulse of (N-1)*2^k clocks is rejected and a pulse of N*2^k clocks is accepted, where N is the window length.
- R6: With tapSel=0, filtOut takes the new level exactly N+3 clocks after the input change, and not earlier. The three extra clocks are two synchroniser stages and the output register.
- R7: riseStb and fallStb are each high for exactly one clock. That clock is the first cycle in which filtOut shows its new level (1 for rise, 0 for fall). The two strobes are never high together.
- R8: Any change of lenSel or tapSel refills the history with the current filtOut level and restarts the prescaler phase. filtOut does not change in the following cycle, and samples taken before the change can never cause a toggle.
- R9: With an 8-sample window at tap 3, a burst of transitions lasting 48 clocks, whose high runs are shorter than one sample period, produces no output transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawIn | input | 1 | Asynchronous raw input line |
| lenSel | input | 2 | Vote window select (2/3/5/8 samples) |
| tapSel | input | 4 | Prescaler tap: one sample per 2^tapSel clocks |
| filtOut | output | 1 | Filtered level |
| riseStb | output | 1 | One-clock strobe on a filtered rising transition |
| fallStb | output | 1 | One-clock strobe on a filtered falling transition |

## Verification
The assertions assume that lenSel and tapSel are driven from the system clock domain and hold defined values from reset onward. Under that assumption, a configuration change seen at one edge must leave filtOut steady at the next edge. The stimulus only changes these fields at falling clock edges, well away from the sampling edge. rawIn is treated as fully asynchronous and is never assumed stable. The bench drives it at falling edges only so that its expected latencies can be counted in whole clocks.

// File: rtl/glf_pkg.sv
package glf_pkg;
  localparam int TAP_W  = 4;
  localparam int CNT_W  = (1 << TAP_W) - 1;
  localparam int HIST_W = 8;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic       sampleStb;
    logic       flush;
    logic [1:0] lenSel;
  } glf_ctrl_t;

  function automatic int winLenOf(input logic [1:0] sel);
    case (sel)
      2'd0: return 2;
      2'd1: return 3;
      2'd2: return 5;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/glf_ctrl.sv
module glf_ctrl
  import glf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       lenSel,
  input  logic [TAP_W-1:0] tapSel,
  output glf_ctrl_t        ctrl
);
  logic [CNT_W-1:0] prescale;
  logic [CNT_W-1:0] tapMask;
  logic [1:0]       lenQ;
  logic [TAP_W-1:0] tapQ;
  logic             cfgChange;

  assign cfgChange = (lenSel != lenQ) || (tapSel != tapQ);
  assign tapMask   = (CNT_W'(1) << tapSel) - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescale <= '0;
      lenQ     <= '0;
      tapQ     <= '0;
    end else begin
      lenQ <= lenSel;
      tapQ <= tapSel;
      if (cfgChange) prescale <= '0;
      else           prescale <= prescale + CNT_W'(1);
    end
  end

  always_comb begin
    ctrl.flush     = cfgChange;
    ctrl.sampleStb = ((prescale & tapMask) == tapMask) && !cfgChange;
    ctrl.lenSel    = lenSel;
  end
endmodule

// File: rtl/glf_datapath.sv
module glf_datapath
  import glf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rawIn,
  input  glf_ctrl_t ctrl,
  output logic      filtOut,
  output logic      riseStb,
  output logic      fallStb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [HIST_W-1:0]      hist;
  logic [HIST_W-1:0]      winMask;
  logic                   allHi;
  logic                   allLo;
  logic                   nextLevel;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[i] <= 1'b0;
        else if (i == 0) syncQ[i] <= rawIn;
        else             syncQ[i] <= syncQ[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               hist <= '0;
    else if (ctrl.flush)     hist <= {HIST_W{filtOut}};
    else if (ctrl.sampleStb) hist <= {hist[HIST_W-2:0], syncQ[SYNC_STAGES-1]};
  end

  always_comb begin
    winMask   = HIST_W'((1 << winLenOf(ctrl.lenSel)) - 1);
    allHi     = (hist & winMask) == winMask;
    allLo     = (hist & winMask) == '0;
    nextLevel = filtOut;
    if (!ctrl.flush) begin
      if (allHi)      nextLevel = 1'b1;
      else if (allLo) nextLevel = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtOut <= 1'b0;
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end else begin
      filtOut <= nextLevel;
      riseStb <= nextLevel && !filtOut;
      fallStb <= !nextLevel && filtOut;
    end
  end
endmodule

// File: rtl/glitch_vote_filter.sv
module glitch_vote_filter
  import glf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic [1:0]       lenSel,
  input  logic [TAP_W-1:0] tapSel,
  output logic             filtOut,
  output logic             riseStb,
  output logic             fallStb
);
  glf_ctrl_t ctrl;

  glf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lenSel(lenSel), .tapSel(tapSel), .ctrl(ctrl)
  );

  glf_datapath u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .ctrl(ctrl),
    .filtOut(filtOut), .riseStb(riseStb), .fallStb(fallStb)
  );
endmodule

// File: rtl/glf_checker.sv
module glf_checker
  import glf_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       lenSel,
  input logic [TAP_W-1:0] tapSel,
  input logic             filtOut,
  input logic             riseStb,
  input logic             fallStb
);
  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> !riseStb);
  // R7
  fall_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |=> !fallStb);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(riseStb && fallStb));
  // R7
  rise_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> (filtOut && !$past(filtOut)));
  // R7
  fall_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> (!filtOut && $past(filtOut)));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((lenSel != $past(lenSel)) || (tapSel != $past(tapSel))) |=> $stable(filtOut));
endmodule

bind glitch_vote_filter glf_checker u_chk (
  .clk(clk), .rstN(rstN), .lenSel(lenSel), .tapSel(tapSel),
  .filtOut(filtOut), .riseStb(riseStb), .fallStb(fallStb)
);

// File: tb/glitch_vote_filter_tb.sv
module glitch_vote_filter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawIn = 1'b0;
  logic [1:0] lenSel = 2'd0;
  logic [3:0] tapSel = 4'd0;
  logic filtOut, riseStb, fallStb;
  int checks = 0;
  int failures = 0;
  int riseCnt = 0;
  int fallCnt = 0;
  logic clrCnt = 1'b0;

  always #2.5 clk = ~clk;

  glitch_vote_filter u_dut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .lenSel(lenSel), .tapSel(tapSel),
    .filtOut(filtOut), .riseStb(riseStb), .fallStb(fallStb)
  );

  always @(negedge clk) begin
    if (clrCnt) begin
      riseCnt <= 0;
      fallCnt <= 0;
    end else if (rstN) begin
      if (riseStb) riseCnt <= riseCnt + 1;
      if (fallStb) fallCnt <= fallCnt + 1;
    end
  end

  // {expect, lenSel, tapSel, width}
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'd0, 16'd1},  {1'b1, 2'd0, 4'd0, 16'd2},
    {1'b0, 2'd1, 4'd0, 16'd2},  {1'b1, 2'd1, 4'd0, 16'd3},
    {1'b0, 2'd2, 4'd0, 16'd4},  {1'b1, 2'd2, 4'd0, 16'd5},
    {1'b0, 2'd3, 4'd0, 16'd7},  {1'b1, 2'd3, 4'd0, 16'd8},
    {1'b0, 2'd0, 4'd2, 16'd4},  {1'b1, 2'd0, 4'd2, 16'd8},
    {1'b0, 2'd3, 4'd3, 16'd56}, {1'b1, 2'd3, 4'd3, 16'd64},
    {1'b0, 2'd2, 4'd4, 16'd64}, {1'b1, 2'd2, 4'd4, 16'd80}
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearCounts();
    clrCnt = 1'b1;
    tick(1);
    clrCnt = 1'b0;
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(3);
    check(filtOut == 0 && riseStb == 0 && fallStb == 0, "R1 during reset",
          {filtOut, riseStb, fallStb}, 0);
    rstN = 1'b1;
    tick(1);
    check(filtOut == 0 && riseStb == 0 && fallStb == 0, "R1 after release",
          {filtOut, riseStb, fallStb}, 0);
    tick(10);

    // R2 R3 R5 table walk
    for (int v = 0; v < NV; v++) begin
      automatic logic exp = VEC[v][22];
      automatic int per = 1 << VEC[v][19:16];
      automatic int w = int'(VEC[v][15:0]);
      lenSel = VEC[v][21:20];
      tapSel = VEC[v][19:16];
      rawIn = 1'b0;
      tick(4);
      clearCounts();
      rawIn = 1'b1;
      tick(w);
      rawIn = 1'b0;
      tick(per * 12 + 12);
      check(filtOut == 1'b0 && riseCnt == int'(exp) && fallCnt == int'(exp),
            $sformatf("R2/R3/R5 vec%0d", v), riseCnt, int'(exp));
    end

    // R6 R7 latency for rise, 8-sample window, tap 0
    lenSel = 2'd3; tapSel = 4'd0; rawIn = 1'b0;
    tick(20);
    rawIn = 1'b1;
    tick(10);
    check(filtOut == 0, "R6 rise not early", filtOut, 0);
    tick(1);
    check(filtOut == 1 && riseStb == 1, "R6 R7 rise at N+3", {filtOut, riseStb}, 3);
    tick(1);
    check(riseStb == 0 && filtOut == 1, "R7 rise one clock", riseStb, 0);

    // R6 R7 latency for fall, 2-sample window
    lenSel = 2'd0;
    tick(5);
    rawIn = 1'b0;
    tick(4);
    check(filtOut == 1, "R6 fall not early", filtOut, 1);
    tick(1);
    check(filtOut == 0 && fallStb == 1, "R6 R7 fall at N+3", {filtOut, fallStb}, 1);
    tick(1);
    check(fallStb == 0, "R7 fall one clock", fallStb, 0);

    // R4 gap removal, 5-sample window
    lenSel = 2'd2; tapSel = 4'd0;
    rawIn = 1'b1;
    tick(20);
    check(filtOut == 1, "R4 settled high", filtOut, 1);
    clearCounts();
    rawIn = 1'b0; tick(4); rawIn = 1'b1;
    tick(20);
    check(filtOut == 1 && fallCnt == 0, "R4 short gap removed", fallCnt, 0);
    rawIn = 1'b0; tick(5); rawIn = 1'b1;
    tick(20);
    check(fallCnt == 1 && riseCnt == 1, "R4 full gap passes", fallCnt, 1);
    rawIn = 1'b0;
    tick(20);

    // R9 chatter burst, 8 samples at tap 3
    lenSel = 2'd3; tapSel = 4'd3;
    tick(4);
    clearCounts();
    for (int b = 0; b < 8; b++) begin
      rawIn = 1'b1; tick(3);
      rawIn = 1'b0; tick(3);
    end
    tick(120);
    check(filtOut == 0 && riseCnt == 0, "R9 burst rejected", riseCnt, 0);

    // R8 config change flushes partial history
    lenSel = 2'd3; tapSel = 4'd0; rawIn = 1'b0;
    tick(20);
    clearCounts();
    rawIn = 1'b1;
    tick(6);
    lenSel = 2'd0; tapSel = 4'd15; rawIn = 1'b0;
    tick(40);
    check(filtOut == 0 && riseCnt == 0, "R8 old samples flushed", riseCnt, 0);
    tapSel = 4'd0;
    tick(20);
    check(filtOut == 0 && riseCnt == 0, "R8 stays low after restore", riseCnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule